// File: doc/BRIEF.md
# Automatic RS-485 Driver Enable

This block sits in the transmit path between a UART and a half-duplex RS-485 transceiver. It watches the serial line and raises the transceiver's driver enable on its own, so software never toggles the direction. Each lane passes its line through one register. A start bit seen on an idle lane asserts the enable in the same clock as the delayed line goes low. The enable then stays high for the frame plus one further idle symbol.

Each lane has three settings: a per-lane enable, the bit time in system clocks, and the number of bits in a character. For example, 8 data bits with no parity and one stop bit give 10 bits per character, and adding even parity gives 11. The timing of the enable comes only from these settings and the observed line. The block does not generate baud timing for data and does not touch the receive path.

Top module: `rs485_autodir`

## Requirements
- R1: `tx_out` equals `tx_in` delayed by exactly one clock on every lane. The lane is idle-high, so `tx_out` resets to 1.
- R2: On an idle, configured lane, a falling edge on `tx_in` makes `drv_en` go to 1 on the same clock edge at which `tx_out` goes to 0.
- R3: For an isolated character, `drv_en` stays high for exactly 2·S·P clocks, where P is the bit time and S is the bits per character: one frame plus one idle symbol. It then returns to 0 while the line is high.
- R4: A start bit that arrives during the idle hold window restarts the frame. `drv_en` stays high without a gap and falls 2·S·P clocks after the last start bit. This includes a start bit that lands on the final clock of the window.
- R5: Back-to-back characters, each starting exactly S·P clocks after the previous one, keep `drv_en` high throughout. It falls 2·S·P clocks after the last start bit.
- R6: Falling edges on data bits inside a frame do not extend the enable. A character of all-zero data bits gives the same enable length as any other character.
- R7: `drv_en` is 0 one clock after any cycle in which the lane's enable is 0, its bit time is 0, or its bit count is 0. Clearing the lane enable during the hold window drops `drv_en` on the next clock.
- R8: Lanes are independent. Traffic on one lane never raises `drv_en` on another.
- R9: After reset, every `drv_en` is 0 and every `tx_out` is 1.
- R10: The bits-per-character setting is honoured, for example 10 for 8N1 and 11 for 8E1, and it changes the enable length according to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_on | input | NP | Per-lane feature enable |
| bit_clks | input | NP·DIV_W | Per-lane bit time in clocks, lane i at [i·DIV_W +: DIV_W] |
| char_bits | input | NP·SYM_W | Per-lane bits per character, lane i at [i·SYM_W +: SYM_W] |
| tx_in | input | NP | Serial transmit lines from the UARTs |
| tx_out | output | NP | Serial lines toward the transceivers, one clock late |
| drv_en | output | NP | Transceiver driver enables |

## Verification
Two events can fall on the same clock edge. The first case is the last tick of a frame coinciding with the next start bit. The second case is the last tick of the idle hold window coinciding with a new start bit. The first is provoked with back-to-back characters and no gap. The second is provoked with a gap of exactly one character time between a stop bit and the next start bit. In both cases the bench requires exactly one rising edge of `drv_en` for the whole burst, and a falling edge exactly 2·S·P clocks after the last start bit. A one-clock drop or a missed restart therefore shows up as an extra rise or a wrong release time.

// File: rtl/rs485_autodir_pkg.sv
package rs485_autodir_pkg;

  // Direction controller phases
  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,  // driver off, watching for a start bit
    DIR_FRAME = 2'd1,  // counting the bits of a character
    DIR_HOLD  = 2'd2   // counting one idle character time
  } dir_state_t;

endpackage

// File: rtl/txen_line_tap.sv
// One register of delay on the serial line, plus start-edge detect.
module txen_line_tap (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out,
  output logic fall
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line_in;
  end

  assign fall     = line_q & ~line_in;
  assign line_out = line_q;
endmodule

// File: rtl/txen_sym_timer.sv
// Counts clocks within a bit and bits within a character.
module txen_sym_timer #(
  parameter int DIV_W = 16,
  parameter int SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] period,
  input  logic [SYM_W-1:0] nbits,
  output logic             sym_done
);
  logic [DIV_W-1:0] tick_q;
  logic [SYM_W-1:0] bit_q;
  logic             bit_end;

  assign bit_end  = (tick_q == period - DIV_W'(1));
  assign sym_done = bit_end && (bit_q == nbits - SYM_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tick_q <= '0;
      bit_q  <= '0;
    end else if (bit_end) begin
      tick_q <= '0;
      bit_q  <= bit_q + SYM_W'(1);
    end else begin
      tick_q <= tick_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/txen_dir_fsm.sv
// Decides driver direction from start edges and symbol timing.
module txen_dir_fsm
  import rs485_autodir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_ok,
  input  logic fall,
  input  logic sym_done,
  output logic tmr_clr,
  output logic drv
);
  dir_state_t st_q, st_nx;

  always_comb begin
    st_nx   = st_q;
    tmr_clr = 1'b0;
    if (!cfg_ok) begin
      st_nx   = DIR_IDLE;
      tmr_clr = 1'b1;
    end else begin
      case (st_q)
        DIR_IDLE: begin
          tmr_clr = 1'b1;
          if (fall) st_nx = DIR_FRAME;
        end
        DIR_FRAME: begin
          // only the closing tick may see a following start bit
          if (sym_done) begin
            tmr_clr = 1'b1;
            st_nx   = fall ? DIR_FRAME : DIR_HOLD;
          end
        end
        DIR_HOLD: begin
          if (fall) begin
            tmr_clr = 1'b1;
            st_nx   = DIR_FRAME;
          end else if (sym_done) begin
            tmr_clr = 1'b1;
            st_nx   = DIR_IDLE;
          end
        end
        default: begin
          tmr_clr = 1'b1;
          st_nx   = DIR_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= DIR_IDLE;
      drv  <= 1'b0;
    end else begin
      st_q <= st_nx;
      drv  <= (st_nx != DIR_IDLE);
    end
  end
endmodule

// File: rtl/txen_lane.sv
// One serial lane: line tap, timer and direction controller.
module txen_lane #(
  parameter int DIV_W = 16,
  parameter int SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  input  logic [DIV_W-1:0] period,
  input  logic [SYM_W-1:0] nbits,
  input  logic             line_in,
  output logic             line_out,
  output logic             drv
);
  logic fall, sym_done, tmr_clr, cfg_ok;

  assign cfg_ok = on && (period != '0) && (nbits != '0);

  txen_line_tap u_tap (
    .clk(clk), .rst(rst), .line_in(line_in),
    .line_out(line_out), .fall(fall)
  );

  txen_sym_timer #(.DIV_W(DIV_W), .SYM_W(SYM_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr),
    .period(period), .nbits(nbits), .sym_done(sym_done)
  );

  txen_dir_fsm u_fsm (
    .clk(clk), .rst(rst), .cfg_ok(cfg_ok), .fall(fall),
    .sym_done(sym_done), .tmr_clr(tmr_clr), .drv(drv)
  );
endmodule

// File: rtl/rs485_autodir.sv
// Automatic driver enable for NP independent serial lanes.
module rs485_autodir #(
  parameter int NP    = 3,
  parameter int DIV_W = 16,
  parameter int SYM_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NP-1:0]       lane_on,
  input  logic [NP*DIV_W-1:0] bit_clks,
  input  logic [NP*SYM_W-1:0] char_bits,
  input  logic [NP-1:0]       tx_in,
  output logic [NP-1:0]       tx_out,
  output logic [NP-1:0]       drv_en
);
  for (genvar i = 0; i < NP; i++) begin : g_lane
    txen_lane #(.DIV_W(DIV_W), .SYM_W(SYM_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .on      (lane_on[i]),
      .period  (bit_clks[i*DIV_W +: DIV_W]),
      .nbits   (char_bits[i*SYM_W +: SYM_W]),
      .line_in (tx_in[i]),
      .line_out(tx_out[i]),
      .drv     (drv_en[i])
    );
  end
endmodule

// File: rtl/rs485_autodir_chk.sv
module rs485_autodir_chk #(
  parameter int NP    = 3,
  parameter int DIV_W = 16,
  parameter int SYM_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NP-1:0]       lane_on,
  input logic [NP*DIV_W-1:0] bit_clks,
  input logic [NP*SYM_W-1:0] char_bits,
  input logic [NP-1:0]       tx_in,
  input logic [NP-1:0]       tx_out,
  input logic [NP-1:0]       drv_en
);
  for (genvar i = 0; i < NP; i++) begin : g_chk
    logic ok;
    assign ok = lane_on[i] && (bit_clks[i*DIV_W +: DIV_W] != '0)
                && (char_bits[i*SYM_W +: SYM_W] != '0);

    assert_pass_delay_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (tx_out[i] == $past(tx_in[i])));

    assert_en_with_start_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(drv_en[i]) |-> $fell(tx_out[i]));

    assert_start_raises_en_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(tx_out[i]) && !$past(drv_en[i]) && $past(ok))
        |-> drv_en[i]);

    assert_release_line_high_R3: assert property (@(posedge clk) disable iff (rst)
      ($fell(drv_en[i]) && $past(ok)) |-> tx_out[i]);

    assert_cfg_off_R7: assert property (@(posedge clk) disable iff (rst)
      !ok |=> !drv_en[i]);
  end
endmodule

bind rs485_autodir rs485_autodir_chk #(.NP(NP), .DIV_W(DIV_W), .SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst(rst), .lane_on(lane_on), .bit_clks(bit_clks),
  .char_bits(char_bits), .tx_in(tx_in), .tx_out(tx_out), .drv_en(drv_en)
);

// File: tb/rs485_autodir_tb.sv
`timescale 1ns/1ps
module rs485_autodir_tb;
  localparam int NP = 2, DIV_W = 16, SYM_W = 4;

  // fields: [39:24] bit time, [23] even parity, [22:20] chars, [19:8] gap, [7:0] first byte
  localparam logic [39:0] VECS [7] = '{
    {16'd4, 1'b0, 3'd1, 12'd0,  8'h55},  // R3 8N1
    {16'd4, 1'b1, 3'd1, 12'd0,  8'h00},  // R6 R10 8E1 zero data
    {16'd7, 1'b0, 3'd3, 12'd0,  8'hA5},  // R5 back-to-back
    {16'd7, 1'b1, 3'd2, 12'd10, 8'h3C},  // R4 start in hold
    {16'd4, 1'b0, 3'd2, 12'd39, 8'h81},  // R4 late start in hold
    {16'd4, 1'b0, 3'd2, 12'd40, 8'h7E},  // R4 start on last hold tick
    {16'd7, 1'b1, 3'd1, 12'd0,  8'hFF}   // R10 8E1
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] lane_on = '1;
  logic [DIV_W-1:0] per [NP];
  logic [SYM_W-1:0] sym [NP];
  logic [NP-1:0] tx_in = '1;
  logic [NP-1:0] tx_out, drv_en;
  logic [NP*DIV_W-1:0] bit_clks;
  logic [NP*SYM_W-1:0] char_bits;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      bit_clks[i*DIV_W +: DIV_W]  = per[i];
      char_bits[i*SYM_W +: SYM_W] = sym[i];
    end
  end

  rs485_autodir #(.NP(NP), .DIV_W(DIV_W), .SYM_W(SYM_W)) u_dut (
    .clk(clk), .rst(rst), .lane_on(lane_on), .bit_clks(bit_clks),
    .char_bits(char_bits), .tx_in(tx_in), .tx_out(tx_out), .drv_en(drv_en)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, last_start = 0;
  int pass_bad = 0;
  int rise_cnt [NP];
  int rise_cyc [NP];
  int fall_cyc [NP];
  logic [NP-1:0] en_prev = '0, in_s = '1;
  bit finished = 0;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    in_s <= tx_in;
  end

  initial for (int i = 0; i < NP; i++) begin rise_cnt[i] = 0; rise_cyc[i] = 0; fall_cyc[i] = 0; end

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (drv_en[p] && !en_prev[p]) begin rise_cnt[p] = rise_cnt[p] + 1; rise_cyc[p] = cyc; end
      if (!drv_en[p] && en_prev[p]) fall_cyc[p] = cyc;
    end
    if (!rst && tx_out != in_s) pass_bad = pass_bad + 1;
    en_prev = drv_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_char(input int p, input logic [7:0] d, input bit par, input int P);
    logic [10:0] fr;
    int n;
    n = par ? 11 : 10;
    fr = '1;
    fr[0] = 1'b0;
    fr[8:1] = d;
    if (par) fr[9] = ^d;
    for (int b = 0; b < n; b++) begin
      tx_in[p] = fr[b];
      if (b == 0 && p == 0) last_start = cyc + 1;
      repeat (P) @(negedge clk);
    end
  endtask

  task automatic cfg(input int p, input int P, input int S);
    per[p] = P[DIV_W-1:0];
    sym[p] = S[SYM_W-1:0];
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin per[i] = 16'd4; sym[i] = 4'd10; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(drv_en == '0, "R9 drv_en after reset", drv_en, 0);
    check(tx_out == '1, "R9 tx_out after reset", tx_out, 3);

    // idle line: no enable
    repeat (200) @(negedge clk);
    check(rise_cnt[0] == 0 && drv_en == '0, "R2 idle line", rise_cnt[0], 0);

    // vector walk on lane 0
    for (int v = 0; v < 7; v++) begin
      int P, S, n, gap, rc1, first;
      bit par;
      P = int'(VECS[v][39:24]); par = VECS[v][23]; n = int'(VECS[v][22:20]);
      gap = int'(VECS[v][19:8]); S = par ? 11 : 10;
      cfg(0, P, S);
      begin
        int rc0;
        rc0 = rise_cnt[0]; rc1 = rise_cnt[1];
        for (int k = 0; k < n; k++) begin
          send_char(0, VECS[v][7:0] + 8'(k), par, P);
          if (k == 0) first = last_start;
          if (k < n - 1) repeat (gap) @(negedge clk);
        end
        repeat (2*S*P + 4) @(negedge clk);
        check(rise_cnt[0] - rc0 == 1, "R4 R5 single enable window", rise_cnt[0] - rc0, 1);
        check(rise_cyc[0] == first, "R2 rise with start bit", rise_cyc[0], first);
        check(fall_cyc[0] == last_start + 2*S*P, "R3 R6 R10 release time",
              fall_cyc[0], last_start + 2*S*P);
        check(rise_cnt[1] == rc1, "R8 other lane quiet", rise_cnt[1] - rc1, 0);
      end
    end
    check(pass_bad == 0, "R1 line pass-through", pass_bad, 0);

    // lane 1 on its own settings
    begin
      int rc0, t0;
      cfg(1, 5, 10);
      rc0 = rise_cnt[0];
      t0 = cyc + 1;
      send_char(1, 8'h33, 1'b0, 5);
      repeat (110) @(negedge clk);
      check(rise_cyc[1] == t0, "R8 lane1 rise", rise_cyc[1], t0);
      check(fall_cyc[1] == t0 + 100, "R8 lane1 release", fall_cyc[1], t0 + 100);
      check(rise_cnt[0] == rc0, "R8 lane0 quiet", rise_cnt[0] - rc0, 0);
    end

    // zero bit time, zero bit count, lane off
    for (int m = 0; m < 3; m++) begin
      int rc0;
      if (m == 0) cfg(0, 0, 10);
      else if (m == 1) cfg(0, 4, 0);
      else begin cfg(0, 4, 10); lane_on[0] = 1'b0; @(negedge clk); end
      rc0 = rise_cnt[0];
      send_char(0, 8'h0F, 1'b0, 4);
      repeat (100) @(negedge clk);
      check(rise_cnt[0] == rc0 && !drv_en[0], "R7 disabled lane stays off", rise_cnt[0] - rc0, 0);
      lane_on[0] = 1'b1;
    end

    // clear lane enable inside hold window
    cfg(0, 4, 10);
    send_char(0, 8'hC3, 1'b0, 4);
    repeat (10) @(negedge clk);
    check(drv_en[0] == 1'b1, "R7 still held before disable", drv_en[0], 1);
    lane_on[0] = 1'b0;
    @(negedge clk);
    check(drv_en[0] == 1'b0, "R7 drop on disable", drv_en[0], 0);
    lane_on[0] = 1'b1;
    repeat (5) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule